// File: doc/BRIEF.md
# Debug Status Read View

This block presents a 32-bit, read-only status word to the processor's debug-access path. The word gathers the two debug communication channel full flags and a set of security and debug-control bits, which arrive as live inputs mirrored from an externally writable debug status register. It also holds a four-bit entry-cause code, which is latched whenever a debug exception is signalled with a recognised cause. Every other bit of the word reads as zero.

A read is a single-cycle strobe. When the flags-only select is low, the whole word appears on the data output one cycle later. When it is high, only the top four bits of the word are returned, as a condition-flag nibble, and the data output keeps its previous value. At the lowest privilege level (level 0) the control bits and the entry code are not architecturally defined. A build parameter decides what the block returns for them there: zeros, the external register's values, or the same values seen at higher levels.

Top module: `dbg_status_view`

## Requirements
- R1: After synchronous reset, rd_data, flags, rd_valid and flags_valid are all zero, and the latched entry code is 4'b0000.
- R2: Bit 30 of the word is rx_full and bit 29 is tx_full, at every privilege level and in every level-0 mode.
- R3: At levels 1 to 3, bit 18 is nonsec, bit 17 is sp_nid_dis, bit 16 is sp_id_dis, bit 15 is mon_en and bit 12 is chan_user_dis.
- R4: On a cycle where exc_pulse is high and exc_code is a legal cause, the latched entry code takes that code on the next edge. The legal causes are 4'b0001 (hardware breakpoint), 4'b0011 (breakpoint instruction), 4'b0101 (vector catch) and 4'b1010 (watchpoint). At levels 1 to 3 the latched code reads back in bits 5:2.
- R5: An illegal exc_code, or exc_pulse low, leaves the latched entry code unchanged.
- R6: Bits 31, 28, 27:19, 14:13, 11:6 and 1:0 of rd_data are always zero.
- R7: A strobe with rd_en high and rd_flags_sel low loads rd_data with the word as sampled at that edge, and pulses rd_valid for one cycle after it.
- R8: A strobe with rd_en high and rd_flags_sel high loads flags with word bits 31:28, ordered {N=bit31, Z=bit30, C=bit29, V=bit28}, and pulses flags_valid one cycle later. rd_data is left unchanged and rd_valid stays low.
- R9: With L0_MODE = 0 (zero mask), a read at level 0 returns zeros in bits 18:15, bit 12 and bits 5:2.
- R10: With L0_MODE = 1 (external), a read at level 0 returns the five control inputs in their positions and ext_entry_code in bits 5:2.
- R11: With L0_MODE = 2 (privileged view), a read at level 0 returns the same word as a read at levels 1 to 3.
- R12: A full read in the same cycle as an exception capture returns the entry code held before that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_full | input | 1 | Receive channel register full |
| tx_full | input | 1 | Transmit channel register full |
| nonsec | input | 1 | Non-secure state |
| sp_nid_dis | input | 1 | Secure privileged non-invasive debug disabled |
| sp_id_dis | input | 1 | Secure privileged invasive debug disabled |
| mon_en | input | 1 | Monitor debug events enabled |
| chan_user_dis | input | 1 | Channel access from level 0 disabled |
| exc_pulse | input | 1 | Debug exception taken this cycle |
| exc_code | input | 4 | Cause of the debug exception |
| ext_entry_code | input | 4 | Entry code currently held by the external register |
| cur_el | input | 2 | Privilege level of the reader (0 = lowest) |
| rd_en | input | 1 | Read strobe |
| rd_flags_sel | input | 1 | 1 = flags-only read, 0 = full read |
| rd_data | output | 32 | Last full-read word |
| rd_valid | output | 1 | rd_data updated this cycle |
| flags | output | 4 | Last flags-only read, {N,Z,C,V} |
| flags_valid | output | 1 | flags updated this cycle |

## Verification
The bench builds three copies of the block side by side, one for each L0_MODE value (0, 1, 2), and drives them all with the same stimulus. This lets a single sweep compare the three level-0 policies against each other. The sweep covers all 32 combinations of the control bits, all four channel-flag combinations and all four privilege levels. Every one of the sixteen cause codes is also pulsed, so each legal capture and each illegal rejection is seen, along with a read that collides with a capture.

// File: rtl/dbg_view_pkg.sv
package dbg_view_pkg;

    localparam int WORD_W = 32;
    localparam int FLAG_W = 4;
    localparam int CODE_W = 4;
    localparam int EL_W   = 2;

    // bit positions inside the status word
    localparam int POS_RXFULL  = 30;
    localparam int POS_TXFULL  = 29;
    localparam int POS_NS      = 18;
    localparam int POS_NIDDIS  = 17;
    localparam int POS_IDDIS   = 16;
    localparam int POS_MONEN   = 15;
    localparam int POS_CHDIS   = 12;
    localparam int POS_CODE_LO = 2;

    // level-0 policies
    localparam int L0_ZERO     = 0;
    localparam int L0_EXTERNAL = 1;
    localparam int L0_PRIV     = 2;

    typedef enum logic [CODE_W-1:0] {
        ENTRY_NONE   = 4'b0000,
        ENTRY_HWBKPT = 4'b0001,
        ENTRY_SWBKPT = 4'b0011,
        ENTRY_VCATCH = 4'b0101,
        ENTRY_WATCH  = 4'b1010
    } entry_cause_e;

    typedef struct packed {
        logic rx_full;
        logic tx_full;
    } chan_flags_t;

    typedef struct packed {
        logic ns;
        logic nid_dis;
        logic id_dis;
        logic mon_en;
        logic ch_dis;
    } sec_ctl_t;

    function automatic logic cause_is_legal(input logic [CODE_W-1:0] code);
        logic ok;
        case (code)
            ENTRY_HWBKPT, ENTRY_SWBKPT,
            ENTRY_VCATCH, ENTRY_WATCH: ok = 1'b1;
            default:                   ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [WORD_W-1:0] place_fields(
        input chan_flags_t        ch,
        input sec_ctl_t           ctl,
        input logic [CODE_W-1:0]  code
    );
        logic [WORD_W-1:0] w;
        w                         = '0;
        w[POS_RXFULL]             = ch.rx_full;
        w[POS_TXFULL]             = ch.tx_full;
        w[POS_NS]                 = ctl.ns;
        w[POS_NIDDIS]             = ctl.nid_dis;
        w[POS_IDDIS]              = ctl.id_dis;
        w[POS_MONEN]              = ctl.mon_en;
        w[POS_CHDIS]              = ctl.ch_dis;
        w[POS_CODE_LO +: CODE_W]  = code;
        return w;
    endfunction

    localparam logic [WORD_W-1:0] USED_MASK     = place_fields('1, '1, '1);
    localparam logic [WORD_W-1:0] RESERVED_MASK = ~USED_MASK;

endpackage

// File: rtl/dbg_entry_capture.sv
module dbg_entry_capture
    import dbg_view_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_pulse,
    input  logic [CODE_W-1:0] exc_code,
    output logic [CODE_W-1:0] code_q
);

    logic take;

    always_comb begin
        take = exc_pulse && cause_is_legal(exc_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= ENTRY_NONE;
        end else if (take) begin
            code_q <= exc_code;
        end
    end

endmodule

// File: rtl/dbg_field_select.sv
module dbg_field_select
    import dbg_view_pkg::*;
#(
    parameter int L0_MODE = L0_ZERO
) (
    input  logic [EL_W-1:0]   cur_el,
    input  sec_ctl_t          ctl_in,
    input  logic [CODE_W-1:0] live_code,
    input  logic [CODE_W-1:0] ext_code,
    output sec_ctl_t          ctl_out,
    output logic [CODE_W-1:0] code_out
);

    logic at_lowest;

    always_comb begin
        at_lowest = (cur_el == '0);
        ctl_out   = ctl_in;
        code_out  = live_code;
        if (at_lowest) begin
            case (L0_MODE)
                L0_ZERO: begin
                    ctl_out  = '0;
                    code_out = '0;
                end
                L0_EXTERNAL: begin
                    ctl_out  = ctl_in;
                    code_out = ext_code;
                end
                default: begin
                    ctl_out  = ctl_in;
                    code_out = live_code;
                end
            endcase
        end
    end

endmodule

// File: rtl/dbg_read_port.sv
module dbg_read_port
    import dbg_view_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_flags_sel,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [FLAG_W-1:0] flags,
    output logic              flags_valid
);

    logic [FLAG_W-1:0] top_bits;

    generate
        for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
            assign top_bits[i] = word[WORD_W-FLAG_W+i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            flags       <= '0;
            flags_valid <= 1'b0;
        end else begin
            rd_valid    <= 1'b0;
            flags_valid <= 1'b0;
            if (rd_en) begin
                if (rd_flags_sel) begin
                    flags       <= top_bits;
                    flags_valid <= 1'b1;
                end else begin
                    rd_data  <= word;
                    rd_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dbg_status_view.sv
module dbg_status_view
    import dbg_view_pkg::*;
#(
    parameter int L0_MODE = L0_ZERO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_full,
    input  logic              tx_full,
    input  logic              nonsec,
    input  logic              sp_nid_dis,
    input  logic              sp_id_dis,
    input  logic              mon_en,
    input  logic              chan_user_dis,
    input  logic              exc_pulse,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] ext_entry_code,
    input  logic [EL_W-1:0]   cur_el,
    input  logic              rd_en,
    input  logic              rd_flags_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [FLAG_W-1:0] flags,
    output logic              flags_valid
);

    chan_flags_t       chan;
    sec_ctl_t          ctl_raw;
    sec_ctl_t          ctl_view;
    logic [CODE_W-1:0] entry_code_q;
    logic [CODE_W-1:0] code_view;
    logic [WORD_W-1:0] view_word;

    always_comb begin
        chan.rx_full    = rx_full;
        chan.tx_full    = tx_full;
        ctl_raw.ns      = nonsec;
        ctl_raw.nid_dis = sp_nid_dis;
        ctl_raw.id_dis  = sp_id_dis;
        ctl_raw.mon_en  = mon_en;
        ctl_raw.ch_dis  = chan_user_dis;
    end

    dbg_entry_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .exc_pulse (exc_pulse),
        .exc_code  (exc_code),
        .code_q    (entry_code_q)
    );

    dbg_field_select #(
        .L0_MODE (L0_MODE)
    ) u_select (
        .cur_el    (cur_el),
        .ctl_in    (ctl_raw),
        .live_code (entry_code_q),
        .ext_code  (ext_entry_code),
        .ctl_out   (ctl_view),
        .code_out  (code_view)
    );

    always_comb begin
        view_word = place_fields(chan, ctl_view, code_view);
    end

    dbg_read_port u_port (
        .clk          (clk),
        .rst          (rst),
        .rd_en        (rd_en),
        .rd_flags_sel (rd_flags_sel),
        .word         (view_word),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .flags        (flags),
        .flags_valid  (flags_valid)
    );

endmodule

// File: rtl/dbg_status_view_chk.sv
module dbg_status_view_chk
    import dbg_view_pkg::*;
#(
    parameter int L0_MODE = L0_ZERO
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_full,
    input logic              tx_full,
    input logic              exc_pulse,
    input logic [CODE_W-1:0] exc_code,
    input logic [CODE_W-1:0] entry_code_q,
    input logic [EL_W-1:0]   cur_el,
    input logic              rd_en,
    input logic              rd_flags_sel,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_valid,
    input logic [FLAG_W-1:0] flags,
    input logic              flags_valid
);

    localparam logic [WORD_W-1:0] L0_FIELDS = place_fields('0, '1, '1);

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (exc_pulse && cause_is_legal(exc_code)) |=> (entry_code_q == $past(exc_code)));

    p_hold_code_r5: assert property (@(posedge clk) disable iff (rst)
        !(exc_pulse && cause_is_legal(exc_code)) |=> $stable(entry_code_q));

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ((rd_data & RESERVED_MASK) == '0));

    p_full_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_flags_sel) |=> (rd_valid && !flags_valid));

    p_flags_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_flags_sel) |=> (flags_valid && !rd_valid && $stable(rd_data)));

    p_flags_chan_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_flags_sel) |=>
            (flags == {1'b0, $past(rx_full), $past(tx_full), 1'b0}));

    p_zero_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (L0_MODE == L0_ZERO && rd_en && !rd_flags_sel && cur_el == '0) |=>
            ((rd_data & L0_FIELDS) == '0));

endmodule

bind dbg_status_view dbg_status_view_chk #(
    .L0_MODE (L0_MODE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_full      (rx_full),
    .tx_full      (tx_full),
    .exc_pulse    (exc_pulse),
    .exc_code     (exc_code),
    .entry_code_q (entry_code_q),
    .cur_el       (cur_el),
    .rd_en        (rd_en),
    .rd_flags_sel (rd_flags_sel),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .flags        (flags),
    .flags_valid  (flags_valid)
);

// File: tb/dbg_status_view_bench.sv
`timescale 1ns/1ps
module dbg_status_view_bench;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       rx_full = 0, tx_full = 0;
    logic       nonsec = 0, sp_nid_dis = 0, sp_id_dis = 0, mon_en = 0, chan_user_dis = 0;
    logic       exc_pulse = 0;
    logic [3:0] exc_code = 0, ext_entry_code = 0;
    logic [1:0] cur_el = 2'd1;
    logic       rd_en = 0, rd_flags_sel = 0;

    logic [31:0] d_z, d_e, d_p;
    logic        v_z, v_e, v_p, fv_z, fv_e, fv_p;
    logic [3:0]  f_z, f_e, f_p;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_code = 4'b0000;

    dbg_status_view #(.L0_MODE(0)) u_dbg_status_view (
        .clk(clk), .rst(rst), .rx_full(rx_full), .tx_full(tx_full), .nonsec(nonsec),
        .sp_nid_dis(sp_nid_dis), .sp_id_dis(sp_id_dis), .mon_en(mon_en),
        .chan_user_dis(chan_user_dis), .exc_pulse(exc_pulse), .exc_code(exc_code),
        .ext_entry_code(ext_entry_code), .cur_el(cur_el), .rd_en(rd_en),
        .rd_flags_sel(rd_flags_sel), .rd_data(d_z), .rd_valid(v_z), .flags(f_z),
        .flags_valid(fv_z));

    dbg_status_view #(.L0_MODE(1)) u_dbg_status_view_ext (
        .clk(clk), .rst(rst), .rx_full(rx_full), .tx_full(tx_full), .nonsec(nonsec),
        .sp_nid_dis(sp_nid_dis), .sp_id_dis(sp_id_dis), .mon_en(mon_en),
        .chan_user_dis(chan_user_dis), .exc_pulse(exc_pulse), .exc_code(exc_code),
        .ext_entry_code(ext_entry_code), .cur_el(cur_el), .rd_en(rd_en),
        .rd_flags_sel(rd_flags_sel), .rd_data(d_e), .rd_valid(v_e), .flags(f_e),
        .flags_valid(fv_e));

    dbg_status_view #(.L0_MODE(2)) u_dbg_status_view_priv (
        .clk(clk), .rst(rst), .rx_full(rx_full), .tx_full(tx_full), .nonsec(nonsec),
        .sp_nid_dis(sp_nid_dis), .sp_id_dis(sp_id_dis), .mon_en(mon_en),
        .chan_user_dis(chan_user_dis), .exc_pulse(exc_pulse), .exc_code(exc_code),
        .ext_entry_code(ext_entry_code), .cur_el(cur_el), .rd_en(rd_en),
        .rd_flags_sel(rd_flags_sel), .rd_data(d_p), .rd_valid(v_p), .flags(f_p),
        .flags_valid(fv_p));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected word from bit positions given in the requirements
    function automatic logic [31:0] model(input logic rx, input logic tx,
                                          input logic [4:0] ctl, input logic [3:0] code);
        return (32'(rx) << 30) | (32'(tx) << 29) | (32'(ctl[4]) << 18) |
               (32'(ctl[3]) << 17) | (32'(ctl[2]) << 16) | (32'(ctl[1]) << 15) |
               (32'(ctl[0]) << 12) | (32'(code) << 2);
    endfunction

    task automatic do_read(input logic sel);
        @(negedge clk);
        rd_en = 1'b1;
        rd_flags_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        rd_flags_sel = 1'b0;
    endtask

    task automatic pulse_exc(input logic [3:0] c);
        @(negedge clk);
        exc_pulse = 1'b1;
        exc_code = c;
        @(negedge clk);
        exc_pulse = 1'b0;
        exc_code = 4'b0000;
    endtask

    function automatic logic legal(input logic [3:0] c);
        return c == 4'b0001 || c == 4'b0011 || c == 4'b0101 || c == 4'b1010;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rd_data", d_z | d_e | d_p, 32'h0);
        chk("R1 flags", {28'h0, f_z | f_e | f_p}, 32'h0);
        chk("R1 valids", {26'h0, v_z, v_e, v_p, fv_z, fv_e, fv_p}, 32'h0);
        rst = 1'b0;
        cur_el = 2'd1;
        do_read(1'b0);
        chk("R1 entry code after reset", d_p, 32'h0);

        // R4: every legal cause code is captured
        for (int k = 0; k < 4; k++) begin
            logic [3:0] c;
            c = (k == 0) ? 4'b0001 : (k == 1) ? 4'b0011 : (k == 2) ? 4'b0101 : 4'b1010;
            pulse_exc(c);
            exp_code = c;
            do_read(1'b0);
            chk("R4 captured code", d_z, model(0, 0, 5'b0, exp_code));
        end

        // R5: illegal codes leave the latch unchanged
        for (int c = 0; c < 16; c++) begin
            if (!legal(4'(c))) begin
                pulse_exc(4'(c));
                do_read(1'b0);
                chk("R5 illegal code ignored", d_e, model(0, 0, 5'b0, exp_code));
            end
        end
        // R5: pulse low with a legal code on the bus
        @(negedge clk);
        exc_code = 4'b0001;
        @(negedge clk);
        exc_code = 4'b0000;
        do_read(1'b0);
        chk("R5 no pulse ignored", d_p, model(0, 0, 5'b0, exp_code));

        // R12: read colliding with a capture sees the prior code
        @(negedge clk);
        exc_pulse = 1'b1;
        exc_code = 4'b0011;
        rd_en = 1'b1;
        @(negedge clk);
        exc_pulse = 1'b0;
        exc_code = 4'b0000;
        rd_en = 1'b0;
        chk("R12 collision returns old code", d_p, model(0, 0, 5'b0, exp_code));
        exp_code = 4'b0011;
        do_read(1'b0);
        chk("R12 new code after collision", d_p, model(0, 0, 5'b0, exp_code));

        // sweep: R2 R3 R6 R7 R8 R9 R10 R11
        for (int ctl = 0; ctl < 32; ctl++) begin
            for (int ch = 0; ch < 4; ch++) begin
                for (int el = 0; el < 4; el++) begin
                    logic [31:0] priv_w, prev;
                    logic [3:0]  ext_c;
                    ext_c = 4'(ctl) ^ 4'h9;
                    @(negedge clk);
                    {nonsec, sp_nid_dis, sp_id_dis, mon_en, chan_user_dis} = 5'(ctl);
                    {rx_full, tx_full} = 2'(ch);
                    cur_el = 2'(el);
                    ext_entry_code = ext_c;
                    do_read(1'b0);
                    priv_w = model(ch[1], ch[0], 5'(ctl), exp_code);
                    chk("R7 rd_valid pulse", {29'h0, v_z, v_e, v_p}, 32'h7);
                    if (el != 0) begin
                        chk("R2/R3/R6 privileged word", d_z, priv_w);
                        chk("R3 privileged word ext mode", d_e, priv_w);
                    end else begin
                        chk("R9 zero mask at level 0", d_z, model(ch[1], ch[0], 5'b0, 4'b0));
                        chk("R10 external at level 0", d_e, model(ch[1], ch[0], 5'(ctl), ext_c));
                    end
                    chk("R11 same as privileged", d_p, priv_w);
                    prev = d_z;
                    do_read(1'b1);
                    chk("R8 flags nibble", {28'h0, f_z}, {28'h0, 1'b0, ch[1], ch[0], 1'b0});
                    chk("R8 flags_valid only", {30'h0, fv_z, v_z}, 32'h2);
                    chk("R8 rd_data held", d_z, prev);
                end
            end
        end

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule